// File: doc/BRIEF.md
# Fine-Grained Thread Select Unit

This unit chooses, every clock cycle, which of several hardware threads issues its next instruction into a single shared in-order pipeline. Selection rotates round-robin, and a thread that is waiting on something slow is taken out of the rotation. The remaining ready threads keep the pipeline busy while it waits.

Four kinds of event put a thread to sleep. Three arrive as per-thread strobes: a cache miss, a trap and a resource conflict. The fourth is a long-latency flag that travels with the instruction being issued, and it applies to the thread currently selected. A per-thread wake strobe returns a sleeping thread to the rotation. A per-thread enable level admits a thread to selection at all, so nothing issues after reset until software-visible start logic raises an enable. A stall input freezes the selection while the pipeline cannot accept an instruction.

The outputs are registered: a selected thread number and a valid flag. At most one thread is selected per cycle.

Top module: `thread_pick`

## Requirements
- R1: After reset, selValid is 0 and selTid is 0. Every thread is ready but none is enabled, so selValid stays 0 until some threadEn bit is 1.
- R2: With every thread enabled, ready and no stall, successive cycles select thread numbers 0, 1, 2, 3, 0, ... in ascending order with wrap-around. Each grant appears on selTid/selValid one clock edge after the state it was chosen from.
- R3: The search for the next grant starts at the thread after the last granted thread. It skips any thread whose threadEn bit is 0 or which is asleep.
- R4: When issueLongLat is 1 at an edge where selValid is 1 and stall is 0, the thread on selTid goes to sleep. It is not selected at that edge or at any later edge until it is woken.
- R5: A 1 on bit i of missStrobe, trapStrobe or conflictStrobe at an edge puts thread i to sleep. Thread i is already excluded from the grant made at that same edge.
- R6: A 1 on bit i of wakeStrobe at an edge makes a sleeping thread i ready. Thread i can be granted from the following edge onward.
- R7: When a sleep event and a wake strobe hit the same thread at the same edge, the thread ends up asleep.
- R8: When no thread is both enabled and ready at an edge without stall, selValid becomes 0.
- R9: While stall is 1, selTid, selValid and the rotation position hold their values. issueLongLat has no effect during stall.
- R10: Miss, trap, conflict and wake strobes still change thread state while stall is 1, and that state governs the first grant after the stall ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| threadEn | input | NUM_THREADS | Per-thread admission level; bit i = 1 lets thread i be selected |
| issueLongLat | input | 1 | Predecode long-latency flag of the instruction issued from selTid |
| missStrobe | input | NUM_THREADS | Per-thread cache-miss sleep strobe |
| trapStrobe | input | NUM_THREADS | Per-thread trap sleep strobe |
| conflictStrobe | input | NUM_THREADS | Per-thread resource-conflict sleep strobe |
| wakeStrobe | input | NUM_THREADS | Per-thread wake strobe (fill, result ready, trap resolved, conflict cleared) |
| stall | input | 1 | Pipeline stall; holds the selection |
| selTid | output | TID_W | Selected thread number |
| selValid | output | 1 | selTid names a thread that issues this cycle |

## Verification
The bench builds the unit with the default of four threads and a two-bit thread number. This width makes the wrap from thread 3 back to thread 0 and the all-asleep case short enough to reach in a few cycles. Four threads are also enough to combine a disabled thread, two sleeping threads and a skipped pointer position in one rotation. It also lets the bench set a wake and a sleep on the same thread at the same edge. It can also let a miss land inside a stall window and see that it shapes the first grant afterwards.

// File: rtl/thread_pick_pkg.sv
package thread_pick_pkg;

  // Strobes from the thread-state control to the selection datapath.
  typedef struct packed {
    logic advance;      // pipeline accepts an instruction this cycle
    logic anyEligible;  // at least one thread may be granted
  } pickCtl_t;

endpackage

// File: rtl/thread_pick_ctrl.sv
module thread_pick_ctrl
  import thread_pick_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] threadEn,
  input  logic                   issueLongLat,
  input  logic [NUM_THREADS-1:0] missStrobe,
  input  logic [NUM_THREADS-1:0] trapStrobe,
  input  logic [NUM_THREADS-1:0] conflictStrobe,
  input  logic [NUM_THREADS-1:0] wakeStrobe,
  input  logic                   stall,
  input  logic [TID_W-1:0]       selTid,
  input  logic                   selValid,
  output logic [NUM_THREADS-1:0] eligible,
  output pickCtl_t               ctl
);

  logic [NUM_THREADS-1:0] readyQ;
  logic [NUM_THREADS-1:0] extKill;
  logic [NUM_THREADS-1:0] issueKill;
  logic [NUM_THREADS-1:0] killAll;
  logic [NUM_THREADS-1:0] readyD;

  assign extKill = missStrobe | trapStrobe | conflictStrobe;

  // The long-latency flag only counts when an instruction really issues.
  for (genvar i = 0; i < NUM_THREADS; i++) begin : g_issueKill
    assign issueKill[i] = issueLongLat && selValid && !stall &&
                          (selTid == TID_W'(i));
  end

  assign killAll  = extKill | issueKill;
  // Sleep beats wake on the same edge.
  assign readyD   = (readyQ | wakeStrobe) & ~killAll;
  // A thread being put to sleep at this edge is not granted at it.
  assign eligible = readyQ & threadEn & ~killAll;

  always_comb begin
    ctl.advance     = !stall;
    ctl.anyEligible = |eligible;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) readyQ <= '1;
    else        readyQ <= readyD;
  end

  // R4: an issued long-latency instruction leaves its thread asleep
  p_issue_sleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (issueLongLat && selValid && !stall) |=> !readyQ[$past(selTid)]);

  // R7 / R5: an external sleep strobe wins over any simultaneous wake
  p_sleep_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((missStrobe | trapStrobe | conflictStrobe) != '0) |=>
      ((readyQ & $past(missStrobe | trapStrobe | conflictStrobe)) == '0));

endmodule

// File: rtl/thread_pick_dp.sv
module thread_pick_dp
  import thread_pick_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] eligible,
  input  pickCtl_t               ctl,
  output logic [TID_W-1:0]       selTid,
  output logic                   selValid
);

  logic [TID_W-1:0] ptrQ;
  logic [TID_W-1:0] pickTid;
  logic [TID_W-1:0] nextPtr;

  // Rotating first-eligible search starting at ptrQ.
  always_comb begin
    logic found;
    int   idx;
    found   = 1'b0;
    pickTid = '0;
    for (int k = 0; k < NUM_THREADS; k++) begin
      idx = int'(ptrQ) + k;
      if (idx >= NUM_THREADS) idx = idx - NUM_THREADS;
      if (!found && eligible[idx]) begin
        found   = 1'b1;
        pickTid = TID_W'(idx);
      end
    end
  end

  assign nextPtr = (int'(pickTid) == NUM_THREADS - 1) ? '0 : pickTid + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptrQ     <= '0;
      selTid   <= '0;
      selValid <= 1'b0;
    end else if (ctl.advance) begin
      selValid <= ctl.anyEligible;
      if (ctl.anyEligible) begin
        selTid <= pickTid;
        ptrQ   <= nextPtr;
      end
    end
  end

  // R9: stall freezes the selection and the rotation position
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.advance |=> ($stable(selTid) && $stable(selValid) && $stable(ptrQ)));

  // R8: nothing eligible gives no valid selection
  p_idle_when_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.advance && (eligible == '0)) |=> !selValid);

  // R3: a fresh grant always names a thread that was eligible
  p_grant_eligible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.advance && (eligible != '0)) |=>
      (selValid && (|($past(eligible) & (NUM_THREADS'(1) << selTid)))));

endmodule

// File: rtl/thread_pick.sv
module thread_pick
  import thread_pick_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] threadEn,
  input  logic                   issueLongLat,
  input  logic [NUM_THREADS-1:0] missStrobe,
  input  logic [NUM_THREADS-1:0] trapStrobe,
  input  logic [NUM_THREADS-1:0] conflictStrobe,
  input  logic [NUM_THREADS-1:0] wakeStrobe,
  input  logic                   stall,
  output logic [TID_W-1:0]       selTid,
  output logic                   selValid
);

  logic [NUM_THREADS-1:0] eligible;
  pickCtl_t               ctl;

  thread_pick_ctrl #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .threadEn       (threadEn),
    .issueLongLat   (issueLongLat),
    .missStrobe     (missStrobe),
    .trapStrobe     (trapStrobe),
    .conflictStrobe (conflictStrobe),
    .wakeStrobe     (wakeStrobe),
    .stall          (stall),
    .selTid         (selTid),
    .selValid       (selValid),
    .eligible       (eligible),
    .ctl            (ctl)
  );

  thread_pick_dp #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .eligible (eligible),
    .ctl      (ctl),
    .selTid   (selTid),
    .selValid (selValid)
  );

endmodule

// File: tb/thread_pick_bench.sv
module thread_pick_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] threadEn;
  logic       issueLongLat;
  logic [3:0] missStrobe, trapStrobe, conflictStrobe, wakeStrobe;
  logic       stall;
  logic [1:0] selTid;
  logic       selValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  thread_pick u_thread_pick (
    .clk(clk), .rst_n(rst_n), .threadEn(threadEn), .issueLongLat(issueLongLat),
    .missStrobe(missStrobe), .trapStrobe(trapStrobe),
    .conflictStrobe(conflictStrobe), .wakeStrobe(wakeStrobe),
    .stall(stall), .selTid(selTid), .selValid(selValid)
  );

  task automatic clearIn();
    issueLongLat = 0; missStrobe = 0; trapStrobe = 0;
    conflictStrobe = 0; wakeStrobe = 0; stall = 0;
  endtask

  task automatic doReset();
    rst_n = 0; threadEn = 0; clearIn();
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  // Advance one edge and sample 1 ns after it.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic expValid, int expTid);
    checks++;
    if (selValid !== expValid || (expValid && selTid !== 2'(expTid))) begin
      fails++;
      $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=%0d",
               req, selValid, selTid, expValid, expTid);
    end
  endtask

  task automatic t_reset_r1();
    doReset();
    chk("R1", 0, 0);
    checks++;
    if (selTid !== 2'd0) begin
      fails++; $display("FAIL R1: tid=%0d expected 0", selTid);
    end
    repeat (3) begin tick(); chk("R1", 0, 0); end
    threadEn = 4'b0100; tick(); chk("R1", 1, 2);
  endtask

  task automatic t_rotate_r2();
    doReset(); threadEn = 4'hF;
    for (int n = 0; n < 6; n++) begin tick(); chk("R2", 1, n % 4); end
  endtask

  task automatic t_skip_r3();
    doReset(); threadEn = 4'b1011;
    tick(); chk("R3", 1, 0);
    tick(); chk("R3", 1, 1);
    tick(); chk("R3", 1, 3);
    tick(); chk("R3", 1, 0);
  endtask

  task automatic t_longlat_r4_r6();
    doReset(); threadEn = 4'hF;
    tick(); chk("R4", 1, 0);
    issueLongLat = 1; tick(); chk("R4", 1, 1);
    issueLongLat = 0;
    tick(); chk("R4", 1, 2);
    tick(); chk("R4", 1, 3);
    tick(); chk("R4", 1, 1);
    wakeStrobe = 4'b0001; tick(); chk("R6", 1, 2);
    wakeStrobe = 0;
    tick(); chk("R6", 1, 3);
    tick(); chk("R6", 1, 0);
  endtask

  task automatic t_events_r5_r8_r7();
    doReset(); threadEn = 4'hF;
    tick(); chk("R5", 1, 0);
    missStrobe = 4'b0010; trapStrobe = 4'b0100; tick(); chk("R5", 1, 3);
    missStrobe = 0; trapStrobe = 0;
    conflictStrobe = 4'b1000; tick(); chk("R5", 1, 0);
    conflictStrobe = 0;
    tick(); chk("R5", 1, 0);
    missStrobe = 4'b0001; tick(); chk("R8", 0, 0);
    missStrobe = 0;
    tick(); chk("R8", 0, 0);
    wakeStrobe = 4'b0001; trapStrobe = 4'b0001; tick(); chk("R7", 0, 0);
    wakeStrobe = 0; trapStrobe = 0;
    tick(); chk("R7", 0, 0);
    wakeStrobe = 4'b0010; tick(); chk("R6", 0, 0);
    wakeStrobe = 0;
    tick(); chk("R6", 1, 1);
  endtask

  task automatic t_stall_r9();
    doReset(); threadEn = 4'hF;
    tick(); chk("R9", 1, 0);
    stall = 1; issueLongLat = 1;
    repeat (3) begin tick(); chk("R9", 1, 0); end
    stall = 0; issueLongLat = 0;
    tick(); chk("R9", 1, 1);
    tick(); chk("R9", 1, 2);
    tick(); chk("R9", 1, 3);
    tick(); chk("R9", 1, 0);
  endtask

  task automatic t_stall_events_r10();
    doReset(); threadEn = 4'hF;
    tick(); chk("R10", 1, 0);
    stall = 1; missStrobe = 4'b0010; tick(); chk("R10", 1, 0);
    missStrobe = 0; stall = 0;
    tick(); chk("R10", 1, 2);
  endtask

  initial begin
    t_reset_r1();
    t_rotate_r2();
    t_skip_r3();
    t_longlat_r4_r6();
    t_events_r5_r8_r7();
    t_stall_r9();
    t_stall_events_r10();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule